// File: doc/BRIEF.md
# Right Shifter with Flag Logic

This block is the right-shift slice of an integer execution unit. On each cycle that `valid_i` is high it takes an operand from the register file and does one of two things. The plain shift moves the operand right and brings in zeros at the top. The double shift moves the operand right and fills the vacated upper bits with the low bits of a second operand. Operands are 8, 16, 32 or 64 bits wide. The result sits zero-extended in a 64-bit bus. The block also works out the new arithmetic flags and tells the register file whether to write them.

The shift amount is a raw 8-bit count that the block masks according to the operand size. A count that masks to zero changes no flag. Overflow is defined only for a one-bit shift, and each operation has its own rule for it. The block handles counts past the operand width in a fixed way and raises status outputs for them. Every output is registered, so the result appears one clock after the request.

Top module: `rsh_unit`

## Requirements
- R1: Outputs are registered with one cycle of latency, and `valid_o` follows `valid_i` one cycle later. Reset clears `valid_o`, `res_o`, `flags_o`, `flags_we_o`, `count_overflow_o` and `illegal_op_o`. Op code: 0 selects the plain shift, 1 the double shift. Size code: 0, 1, 2 and 3 select 8, 16, 32 and 64 bits.
- R2: The count is masked to its low 5 bits for 8-, 16- and 32-bit sizes, and to its low 6 bits for the 64-bit size.
- R3: When the masked count is 0, `res_o` is the operand cut to its size, `flags_o` equals `flags_i`, and `flags_we_o` is 0.
- R4: The plain shift brings in a 0 at the top for every position shifted. The result is zero above the operand size. Carry is the last bit shifted out of the operand's low end, which is operand bit (count-1).
- R5: A plain shift at 8 or 16 bits with a masked count of at least the operand width gives a result of 0 and a carry of 0.
- R6: A plain shift by 1 sets overflow to the top bit of the original operand.
- R7: For any masked count above 1, overflow is 0.
- R8: The double shift fills the vacated top bits with the low bits of the fill operand, in order. A count equal to the width returns the fill operand. Carry is operand bit (count-1).
- R9: A double shift by 1 sets overflow to 1 exactly when the top bit of the result differs from the top bit of the original operand.
- R10: A double shift whose masked count exceeds the operand width gives a result of 0 with carry 0 and overflow 0. It raises `count_overflow_o`, and the flags are still written.
- R11: A double shift at size 8 is rejected. `illegal_op_o` goes to 1, the result is the operand cut to 8 bits, and the flags pass through unwritten.
- R12: The flag vector is laid out as bit0 carry, bit1 parity, bit2 auxiliary carry, bit3 zero, bit4 sign, bit5 overflow. Sign is the result's top bit at the operand size. Zero is 1 when the result is 0. Parity is 1 when the low 8 result bits hold an even number of ones. Auxiliary carry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 1 | 0 plain shift, 1 double shift |
| size_i | input | 2 | Operand size code: 0/1/2/3 = 8/16/32/64 bits |
| dst_i | input | 64 | Operand to shift |
| src_i | input | 64 | Fill operand for the double shift |
| cnt_i | input | 8 | Raw shift count |
| flags_i | input | 6 | Incoming flags |
| valid_o | output | 1 | Result valid |
| res_o | output | 64 | Result, zero-extended |
| flags_o | output | 6 | Outgoing flags |
| flags_we_o | output | 1 | Flag write enable |
| count_overflow_o | output | 1 | Double-shift count exceeded the width |
| illegal_op_o | output | 1 | Rejected operation |

## Verification
The bench builds the block with its default parameters: a 64-bit data path and an 8-bit raw count. With these defaults all four operand sizes are available, including the 64-bit case with its 6-bit count mask. These defaults also make two corner cases reachable, because the 5-bit mask lets counts pass the width at 8 and 16 bits. One is a plain shift at or past the width. The other is a double shift that reaches or exceeds 16 bits. Sweeps over every count at 32-bit plain and 16-bit double size exercise each carry position and each edge of the count range.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 8;
  localparam int FLG_W  = 6;
  localparam int N_SIZE = 4;

  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;

  typedef enum logic {
    OP_SHR  = 1'b0,
    OP_DSHR = 1'b1
  } rsh_op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } rsh_size_e;

  function automatic int unsigned size_bits(rsh_size_e s);
    return 32'd8 << s;
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(rsh_size_e s);
    case (s)
      SZ_8:    return DATA_W'(8'hFF);
      SZ_16:   return DATA_W'(16'hFFFF);
      SZ_32:   return DATA_W'(32'hFFFF_FFFF);
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  function automatic logic msb_of(logic [DATA_W-1:0] v, rsh_size_e s);
    case (s)
      SZ_8:    return v[7];
      SZ_16:   return v[15];
      SZ_32:   return v[31];
      default: return v[DATA_W-1];
    endcase
  endfunction

  function automatic logic even_parity8(logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/rsh_count_mask.sv
module rsh_count_mask
  import rsh_pkg::*;
#(
  parameter int CNT_W_P  = CNT_W,
  parameter int DATA_W_P = DATA_W
) (
  input  logic [CNT_W_P-1:0] cnt_i,
  input  rsh_size_e          size_i,
  input  rsh_op_e            op_i,
  output logic [CNT_W_P-1:0] amt_o,
  output logic               zero_o,
  output logic               past_width_o,
  output logic               beyond_width_o,
  output logic               illegal_o
);
  localparam int WIDE_BITS   = $clog2(DATA_W_P);
  localparam int NARROW_BITS = WIDE_BITS - 1;
  localparam logic [CNT_W_P-1:0] WIDE_MASK   = CNT_W_P'((1 << WIDE_BITS) - 1);
  localparam logic [CNT_W_P-1:0] NARROW_MASK = CNT_W_P'((1 << NARROW_BITS) - 1);

  logic [CNT_W_P-1:0] width_cnt;

  always_comb begin
    amt_o          = cnt_i & ((size_i == SZ_64) ? WIDE_MASK : NARROW_MASK);
    width_cnt      = CNT_W_P'(size_bits(size_i));
    zero_o         = (amt_o == '0);
    past_width_o   = (amt_o >= width_cnt);
    beyond_width_o = (amt_o > width_cnt);
    illegal_o      = (op_i == OP_DSHR) && (size_i == SZ_8);
  end
endmodule

// File: rtl/rsh_datapath.sv
module rsh_datapath
  import rsh_pkg::*;
#(
  parameter int CNT_W_P  = CNT_W,
  parameter int DATA_W_P = DATA_W
) (
  input  rsh_op_e             op_i,
  input  rsh_size_e           size_i,
  input  logic [DATA_W_P-1:0] dst_i,
  input  logic [DATA_W_P-1:0] src_i,
  input  logic [CNT_W_P-1:0]  amt_i,
  input  logic                past_width_i,
  input  logic                beyond_width_i,
  output logic [DATA_W_P-1:0] res_o,
  output logic                carry_o,
  output logic                ovf_o,
  output logic                cnt_ovf_o
);
  logic [DATA_W_P-1:0]   mask, dst_w, src_w, res_raw;
  logic [2*DATA_W_P-1:0] pair;
  logic [CNT_W_P-1:0]    amt_m1;
  logic                  carry_pick, one_bit;

  always_comb begin
    mask   = width_mask(size_i);
    dst_w  = dst_i & mask;
    src_w  = src_i & mask;
    pair   = {{DATA_W_P{1'b0}}, dst_w};
    if (op_i == OP_DSHR)
      pair = pair | ({{DATA_W_P{1'b0}}, src_w} << size_bits(size_i));
    res_raw    = DATA_W_P'(pair >> amt_i) & mask;
    amt_m1     = amt_i - CNT_W_P'(1);
    carry_pick = |(dst_w & (DATA_W_P'(1) << amt_m1));
    one_bit    = (amt_i == CNT_W_P'(1));

    res_o     = res_raw;
    carry_o   = carry_pick;
    cnt_ovf_o = 1'b0;
    if (op_i == OP_SHR) begin
      if (past_width_i) begin
        res_o   = '0;
        carry_o = 1'b0;
      end
    end else if (beyond_width_i) begin
      res_o     = '0;
      carry_o   = 1'b0;
      cnt_ovf_o = 1'b1;
    end

    ovf_o = 1'b0;
    if (one_bit) begin
      if (op_i == OP_SHR) ovf_o = msb_of(dst_w, size_i);
      else                ovf_o = msb_of(res_o, size_i) ^ msb_of(dst_w, size_i);
    end
  end
endmodule

// File: rtl/rsh_flag_gen.sv
module rsh_flag_gen
  import rsh_pkg::*;
#(
  parameter int DATA_W_P = DATA_W
) (
  input  logic [DATA_W_P-1:0] res_i,
  input  rsh_size_e           size_i,
  input  logic                carry_i,
  input  logic                ovf_i,
  input  logic                write_i,
  input  logic [FLG_W-1:0]    flags_i,
  output logic [FLG_W-1:0]    flags_o
);
  logic [N_SIZE-1:0] sign_by_size;

  for (genvar k = 0; k < N_SIZE; k++) begin : g_sign
    assign sign_by_size[k] = res_i[(8 << k) - 1];
  end

  always_comb begin
    flags_o = flags_i;
    if (write_i) begin
      flags_o[FL_CF] = carry_i;
      flags_o[FL_PF] = even_parity8(res_i[7:0]);
      flags_o[FL_AF] = 1'b0;
      flags_o[FL_ZF] = (res_i == '0);
      flags_o[FL_SF] = sign_by_size[size_i];
      flags_o[FL_OF] = ovf_i;
    end
  end
endmodule

// File: rtl/rsh_unit.sv
module rsh_unit
  import rsh_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int CNT_W_P  = CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic                op_i,
  input  logic [1:0]          size_i,
  input  logic [DATA_W_P-1:0] dst_i,
  input  logic [DATA_W_P-1:0] src_i,
  input  logic [CNT_W_P-1:0]  cnt_i,
  input  logic [FLG_W-1:0]    flags_i,
  output logic                valid_o,
  output logic [DATA_W_P-1:0] res_o,
  output logic [FLG_W-1:0]    flags_o,
  output logic                flags_we_o,
  output logic                count_overflow_o,
  output logic                illegal_op_o
);
  rsh_op_e             op_e;
  rsh_size_e           size_e;
  logic [CNT_W_P-1:0]  amt;
  logic                ev_zero_cnt, ev_past_width, ev_beyond_width, ev_illegal;
  logic [DATA_W_P-1:0] dp_res, res_next;
  logic                dp_carry, dp_ovf, ev_cnt_ovf, flag_write;
  logic [FLG_W-1:0]    flags_next;

  assign op_e   = rsh_op_e'(op_i);
  assign size_e = rsh_size_e'(size_i);

  rsh_count_mask #(.CNT_W_P(CNT_W_P), .DATA_W_P(DATA_W_P)) u_mask (
    .cnt_i          (cnt_i),
    .size_i         (size_e),
    .op_i           (op_e),
    .amt_o          (amt),
    .zero_o         (ev_zero_cnt),
    .past_width_o   (ev_past_width),
    .beyond_width_o (ev_beyond_width),
    .illegal_o      (ev_illegal)
  );

  rsh_datapath #(.CNT_W_P(CNT_W_P), .DATA_W_P(DATA_W_P)) u_dp (
    .op_i           (op_e),
    .size_i         (size_e),
    .dst_i          (dst_i),
    .src_i          (src_i),
    .amt_i          (amt),
    .past_width_i   (ev_past_width),
    .beyond_width_i (ev_beyond_width),
    .res_o          (dp_res),
    .carry_o        (dp_carry),
    .ovf_o          (dp_ovf),
    .cnt_ovf_o      (ev_cnt_ovf)
  );

  assign flag_write = !ev_zero_cnt && !ev_illegal;
  assign res_next   = ev_illegal ? (dst_i & width_mask(size_e)) : dp_res;

  rsh_flag_gen #(.DATA_W_P(DATA_W_P)) u_flags (
    .res_i   (res_next),
    .size_i  (size_e),
    .carry_i (dp_carry),
    .ovf_i   (dp_ovf),
    .write_i (flag_write),
    .flags_i (flags_i),
    .flags_o (flags_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o          <= 1'b0;
      res_o            <= '0;
      flags_o          <= '0;
      flags_we_o       <= 1'b0;
      count_overflow_o <= 1'b0;
      illegal_op_o     <= 1'b0;
    end else begin
      valid_o          <= valid_i;
      flags_we_o       <= valid_i && flag_write;
      count_overflow_o <= valid_i && ev_cnt_ovf && !ev_illegal;
      illegal_op_o     <= valid_i && ev_illegal;
      if (valid_i) begin
        res_o   <= res_next;
        flags_o <= flags_next;
      end
    end
  end
endmodule

// File: rtl/rsh_unit_chk.sv
module rsh_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic        op_i,
  input logic [1:0]  size_i,
  input logic [7:0]  cnt_i,
  input logic [5:0]  flags_i,
  input logic        valid_o,
  input logic [63:0] res_o,
  input logic [5:0]  flags_o,
  input logic        flags_we_o,
  input logic        count_overflow_o,
  input logic        illegal_op_o
);
  logic [7:0] chk_amt;
  assign chk_amt = cnt_i & ((size_i == 2'd3) ? 8'h3F : 8'h1F);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && !flags_we_o));
  p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && chk_amt == 8'd0) |=> (!flags_we_o && flags_o == $past(flags_i)));
  p_shr_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !op_i && size_i == 2'd3 && chk_amt != 8'd0) |=> !res_o[63]);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && chk_amt > 8'd1) |=> (!flags_o[5] || !flags_we_o));
  p_cnt_ovf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count_overflow_o |-> (res_o == 64'd0 && flags_we_o));
  p_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i && size_i == 2'd0) |=> (illegal_op_o && !flags_we_o));
  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_op_o, count_overflow_o}));
  p_af_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we_o |-> !flags_o[2]);
  p_zf_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we_o |-> (flags_o[3] == (res_o == 64'd0)));
endmodule

bind rsh_unit rsh_unit_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .valid_i          (valid_i),
  .op_i             (op_i),
  .size_i           (size_i),
  .cnt_i            (cnt_i),
  .flags_i          (flags_i),
  .valid_o          (valid_o),
  .res_o            (res_o),
  .flags_o          (flags_o),
  .flags_we_o       (flags_we_o),
  .count_overflow_o (count_overflow_o),
  .illegal_op_o     (illegal_op_o)
);

// File: tb/rsh_unit_test.sv
module rsh_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [63:0] dst_i = '0;
  logic [63:0] src_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [5:0]  flags_i = '0;
  logic        valid_o;
  logic [63:0] res_o;
  logic [5:0]  flags_o;
  logic        flags_we_o, count_overflow_o, illegal_op_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rsh_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i), .flags_i(flags_i),
    .valid_o(valid_o), .res_o(res_o), .flags_o(flags_o), .flags_we_o(flags_we_o),
    .count_overflow_o(count_overflow_o), .illegal_op_o(illegal_op_o)
  );

  typedef struct packed {
    logic        op;
    logic [1:0]  size;
    logic [63:0] dst;
    logic [63:0] src;
    logic [7:0]  cnt;
    logic [63:0] e_res;
    logic [5:0]  e_flg;
    logic        e_we;
    logic        e_cov;
    logic        e_ill;
  } vec_t;

  localparam int NV = 14;
  localparam logic [63:0] D8 = 64'hFFFF_FFFF_FFFF_FFB5;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, D8, 64'd0, 8'd1,    64'h5A, 6'h23, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, D8, 64'd0, 8'hE3,   64'h16, 6'h01, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, D8, 64'd0, 8'd8,    64'h00, 6'h0A, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, D8, 64'd0, 8'h20,   64'hB5, 6'h2A, 1'b0, 1'b0, 1'b0},
    '{1'b0, 2'd3, 64'h8000_0000_0000_0001, 64'd0, 8'h7F, 64'h1, 6'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd2, 64'hDEAD_BEEF_C000_0000, 64'd0, 8'h3F, 64'h1, 6'h01, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd1, 64'h1234, 64'hABCD, 8'd4,  64'hD123, 6'h10, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd1, 64'h1234, 64'hABCD, 8'd16, 64'hABCD, 6'h10, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd1, 64'h1234, 64'hABCD, 8'd17, 64'h0,    6'h0A, 1'b1, 1'b1, 1'b0},
    '{1'b1, 2'd2, 64'h1, 64'h1, 8'd1, 64'h8000_0000, 6'h33, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd0, D8, 64'h77, 8'd3, 64'hB5, 6'h2A, 1'b0, 1'b0, 1'b1},
    '{1'b1, 2'd3, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 8'd8,
      64'h1001_2345_6789_ABCD, 6'h01, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd1, 64'h8000, 64'd0, 8'd1, 64'h4000, 6'h22, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd3, 64'h8000_0000_0000_0000, 64'd0, 8'd1,
      64'h4000_0000_0000_0000, 6'h22, 1'b1, 1'b0, 1'b0}
  };
  localparam string VTAG [NV] = '{
    "R4 R6 R12", "R2 R4", "R5", "R2 R3", "R2 R4", "R2 R4",
    "R8 R7", "R8", "R10", "R9 R12", "R11", "R8", "R6", "R9"
  };

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic op, logic [1:0] sz, logic [63:0] d, logic [63:0] s,
                       logic [7:0] c, logic [5:0] f);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; size_i = sz; dst_i = d; src_i = s; cnt_i = c; flags_i = f;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // Independent bit-by-bit model of the shifted value
  function automatic logic [63:0] model_res(logic op, int w, logic [63:0] d,
                                            logic [63:0] s, int m);
    logic [63:0] r = '0;
    if (!op && m >= w) return '0;
    if (op && m > w) return '0;
    for (int i = 0; i < w; i++) begin
      if (i + m < w)          r[i] = d[i + m];
      else if (op)            r[i] = s[i + m - w];
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid_o at reset", 64'(valid_o), 64'd0);
    chk("R1", "res_o at reset", res_o, 64'd0);
    chk("R1", "flags_we_o at reset", 64'(flags_we_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle valid_o", 64'(valid_o), 64'd0);

    // Table of vectors
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].op, VEC[v].size, VEC[v].dst, VEC[v].src, VEC[v].cnt, 6'h2A);
      chk(VTAG[v], "valid_o", 64'(valid_o), 64'd1);
      chk(VTAG[v], "res_o", res_o, VEC[v].e_res);
      chk(VTAG[v], "flags_o", 64'(flags_o), 64'(VEC[v].e_flg));
      chk(VTAG[v], "flags_we_o", 64'(flags_we_o), 64'(VEC[v].e_we));
      chk(VTAG[v], "count_overflow_o", 64'(count_overflow_o), 64'(VEC[v].e_cov));
      chk(VTAG[v], "illegal_op_o", 64'(illegal_op_o), 64'(VEC[v].e_ill));
    end

    // R1: valid drops after the request
    @(negedge clk);
    chk("R1", "valid_o after idle", 64'(valid_o), 64'd0);

    // R2 R3: 64-bit count 0x40 masks to zero
    drive(1'b0, 2'd3, 64'hF0F0_0000_1234_5678, 64'd0, 8'h40, 6'h15);
    chk("R2", "64-bit masked zero res", res_o, 64'hF0F0_0000_1234_5678);
    chk("R3", "64-bit masked zero flags", 64'(flags_o), 64'h15);
    chk("R3", "64-bit masked zero we", 64'(flags_we_o), 64'd0);

    // R4: sweep of 32-bit plain shift over every count
    for (int m = 0; m < 32; m++) begin
      logic [63:0] d = 64'h5555_0000_A5C3_0F96;
      drive(1'b0, 2'd2, d, 64'd0, 8'(m), 6'h15);
      chk("R4", "shr32 sweep res", res_o, model_res(1'b0, 32, d & 64'hFFFF_FFFF, 64'd0, m));
      chk("R4", "shr32 sweep carry", 64'(flags_o[0]), (m == 0) ? 64'd1 : 64'(d[m - 1]));
      chk("R3", "shr32 sweep we", 64'(flags_we_o), (m == 0) ? 64'd0 : 64'd1);
    end

    // R8 R10: sweep of 16-bit double shift over every count
    for (int m = 0; m < 32; m++) begin
      logic [63:0] d = 64'h0000_0000_0000_9C3A;
      logic [63:0] s = 64'h1111_2222_3333_5E71;
      logic        ec;
      ec = (m == 0) ? 1'b1 : (m <= 16) ? d[m - 1] : 1'b0;
      drive(1'b1, 2'd1, d, s, 8'(m), 6'h15);
      chk("R8", "dshr16 sweep res", res_o, model_res(1'b1, 16, d, s & 64'hFFFF, m));
      chk("R8", "dshr16 sweep carry", 64'(flags_o[0]), 64'(ec));
      chk("R10", "dshr16 sweep count_overflow", 64'(count_overflow_o), (m > 16) ? 64'd1 : 64'd0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule